// File: doc/BRIEF.md
# Regulator Startup and Fault Supervisor

This block sequences a multiphase buck regulator from power-up to regulation and shuts it down when the output misbehaves. It holds the gate drivers in high impedance until the supply is good and the enable is high. It then runs soft-start towards the boot setpoint. Once the output sits inside the boot window, it waits for the power-good of the neighbouring rails. When that arrives, it strobes the VID capture and switches the reference to the VID setpoint.

The power-good pin is open drain, so the block only drives a pull-down. The pull is released once the output reaches the boot window, which lets the external rails' power-good be read on the same wire. In regulation, a drop out of the window is hidden while a slew (a VID change or a sleep-mode change) is in flight.

Overvoltage, undervoltage and a filtered overcurrent latch the converter off. The undervoltage and overcurrent latch is cleared by toggling the enable. The overvoltage latch is cleared only by losing the supply. The comparators and PWM generation live outside this block. The block sees only their flags and a once-per-switching-cycle tick.

Top module: `vr_supervisor`

## Requirements
- R1: While rst_ni is low, the state is OFF, drv_en_o=0, vid_sel_o=0, vid_cap_o=0 and pg_pull_o=1.
- R2: drv_en_o is 1 only in SOFTSTART, BOOT_WAIT and RUN. From OFF, the block enters SOFTSTART on the clock edge where supply_ok_i and en_i are both 1. en_i=0 in SOFTSTART, BOOT_WAIT or RUN returns the block to OFF on the next edge.
- R3: supply_ok_i=0 forces OFF on the next edge from any state, including both fault states.
- R4: SOFTSTART moves to BOOT_WAIT on the edge where vout_win_i=1. vid_sel_o=0 (boot setpoint) in every state but RUN, where it is 1 (VID setpoint).
- R5: BOOT_WAIT moves to RUN on the edge where ext_pg_i=1 and no fault is present. vid_cap_o is 1 for exactly the first RUN cycle.
- R6: pg_pull_o=1 in OFF, SOFTSTART and both fault states, and 0 in BOOT_WAIT. In RUN it is 1 exactly when vout_win_i=0 and slew_busy_i=0.
- R7: An overcurrent trip needs OC_CYCLES (default 32) consecutive cycles with cyc_tick_i=1 and oc_i=1. A tick with oc_i=0 restarts the count, and cycles with cyc_tick_i=0 neither count nor restart it.
- R8: ov_i, uv_i and oc_i have no effect in OFF and SOFTSTART, and the overcurrent count restarts there.
- R9: In BOOT_WAIT or RUN with en_i=1, ov_i=1 enters FAULT_OV. Otherwise uv_i=1 or an overcurrent trip enters FAULT_UVOC. ov_i wins when both are present.
- R10: FAULT_UVOC leaves to OFF when en_i=0. FAULT_OV ignores en_i and leaves only through R3.
- R11: state_oh_o is always one-hot, with bit 0 OFF, bit 1 SOFTSTART, bit 2 BOOT_WAIT, bit 3 RUN, bit 4 FAULT_UVOC and bit 5 FAULT_OV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above power-on threshold |
| en_i | input | 1 | Regulator enable |
| vout_win_i | input | 1 | Output inside the regulation window of the current setpoint |
| ext_pg_i | input | 1 | Power-good of the external rails, read from the shared pin |
| slew_busy_i | input | 1 | Setpoint or mode slew in progress; masks power-good |
| cyc_tick_i | input | 1 | One pulse per switching cycle |
| ov_i | input | 1 | Overvoltage comparator flag |
| uv_i | input | 1 | Undervoltage comparator flag |
| oc_i | input | 1 | Overcurrent comparator flag |
| drv_en_o | output | 1 | Gate drivers active (0 = high impedance) |
| vid_sel_o | output | 1 | Reference select: 0 boot, 1 VID |
| vid_cap_o | output | 1 | One-cycle VID capture strobe |
| pg_pull_o | output | 1 | Open-drain power-good pull-down active |
| state_oh_o | output | 6 | One-hot state |

## Verification
The bench drives the overcurrent filter to 31 ticks, breaks the run with one clean tick, and interleaves idle cycles. A filter that counted non-tick cycles, or did not restart, would trip early; an off-by-one count would trip at 31 or 33 ticks. Enable toggles in both fault states separate the two recovery paths, since a shared recovery path would leave the overvoltage latch on the enable toggle. Faults held throughout soft-start would wrongly latch a design that armed early. A simultaneous overvoltage and undervoltage must pick the overvoltage latch. Power-good is checked with a slew in flight while the output sits outside the window, where a missing mask would pull the pin low.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_SS   = 3'd1,
    ST_BW   = 3'd2,
    ST_RUN  = 3'd3,
    ST_FUV  = 3'd4,
    ST_FOV  = 3'd5
  } vrs_state_e;
  localparam int unsigned NUM_ST = 6;
endpackage

// File: rtl/vrs_oc_filter.sv
module vrs_oc_filter #(
  parameter int unsigned OC_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  input  logic oc_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(OC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign trip_o = arm_i & tick_i & oc_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!arm_i)      cnt_q <= '0;
    else if (tick_i) begin
      if (!oc_i)          cnt_q <= '0;
      else if (!trip_o)   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vrs_fsm.sv
module vrs_fsm
  import vrs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       en_i,
  input  logic       vout_win_i,
  input  logic       ext_pg_i,
  input  logic       ov_i,
  input  logic       uv_i,
  input  logic       oc_trip_i,
  output vrs_state_e state_o,
  output logic       arm_o,
  output logic       go_run_o
);
  vrs_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    go_run_o = 1'b0;
    if (!supply_ok_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: if (en_i) state_d = ST_SS;
        ST_SS: begin
          if (!en_i)           state_d = ST_OFF;
          else if (vout_win_i) state_d = ST_BW;
        end
        ST_BW, ST_RUN: begin
          if (!en_i)                  state_d = ST_OFF;
          else if (ov_i)              state_d = ST_FOV;
          else if (uv_i || oc_trip_i) state_d = ST_FUV;
          else if (state_q == ST_BW && ext_pg_i) begin
            state_d  = ST_RUN;
            go_run_o = 1'b1;
          end
        end
        ST_FUV: if (!en_i) state_d = ST_OFF;
        ST_FOV: state_d = ST_FOV;  // only supply loss clears
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign arm_o   = (state_q == ST_BW) || (state_q == ST_RUN);
endmodule

// File: rtl/vr_supervisor.sv
module vr_supervisor
  import vrs_pkg::*;
#(
  parameter int unsigned OC_CYCLES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              en_i,
  input  logic              vout_win_i,
  input  logic              ext_pg_i,
  input  logic              slew_busy_i,
  input  logic              cyc_tick_i,
  input  logic              ov_i,
  input  logic              uv_i,
  input  logic              oc_i,
  output logic              drv_en_o,
  output logic              vid_sel_o,
  output logic              vid_cap_o,
  output logic              pg_pull_o,
  output logic [NUM_ST-1:0] state_oh_o
);
  vrs_state_e state;
  logic arm, trip, go_run, cap_q;

  vrs_oc_filter #(.OC_CYCLES(OC_CYCLES)) u_oc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .tick_i (cyc_tick_i),
    .oc_i   (oc_i),
    .trip_o (trip)
  );

  vrs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .en_i        (en_i),
    .vout_win_i  (vout_win_i),
    .ext_pg_i    (ext_pg_i),
    .ov_i        (ov_i),
    .uv_i        (uv_i),
    .oc_trip_i   (trip),
    .state_o     (state),
    .arm_o       (arm),
    .go_run_o    (go_run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= go_run;
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_oh
    assign state_oh_o[g] = (state == vrs_state_e'(3'(g)));
  end

  assign drv_en_o  = (state == ST_SS) || (state == ST_BW) || (state == ST_RUN);
  assign vid_sel_o = (state == ST_RUN);
  assign vid_cap_o = cap_q;

  always_comb begin
    unique case (state)
      ST_BW:   pg_pull_o = 1'b0;  // pin read as input from external rails
      ST_RUN:  pg_pull_o = !vout_win_i && !slew_busy_i;
      default: pg_pull_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       en_i,
  input logic       vout_win_i,
  input logic       vid_cap_o,
  input logic       drv_en_o,
  input logic       pg_pull_o,
  input logic [5:0] state_oh_o
);
  assert_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_oh_o) == 1);

  assert_supply_loss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> state_oh_o[0]);

  assert_en_low_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !state_oh_o[5]) |=> !drv_en_o);

  assert_cap_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_cap_o |-> (state_oh_o[3] && $past(state_oh_o[2])));

  assert_ov_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_oh_o[5] && supply_ok_i) |=> state_oh_o[5]);

  assert_pg_low_early_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_oh_o[0] || state_oh_o[1]) |-> pg_pull_o);

  assert_ss_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_oh_o[1] && supply_ok_i && en_i && !vout_win_i) |=> state_oh_o[1]);
endmodule

bind vr_supervisor vrs_checker u_chk (.*);

// File: tb/vr_supervisor_tb.sv
`timescale 1ns/100ps
module vr_supervisor_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic supply_ok = 0, en = 0, win = 0, xpg = 0, slew = 0, tick = 0, ov = 0, uv = 0, oc = 0;
  logic drv_en, vid_sel, vid_cap, pg_pull;
  logic [5:0] soh;

  vr_supervisor u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .en_i(en),
    .vout_win_i(win), .ext_pg_i(xpg), .slew_busy_i(slew), .cyc_tick_i(tick),
    .ov_i(ov), .uv_i(uv), .oc_i(oc), .drv_en_o(drv_en), .vid_sel_o(vid_sel),
    .vid_cap_o(vid_cap), .pg_pull_o(pg_pull), .state_oh_o(soh)
  );

  always #2.5 clk = ~clk;

  int vec = 0, miss = 0;
  int ms = 0, moc = 0;
  bit mcap = 0;

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    vec++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit exp_pull(int s, bit w, bit b);
    if (s == 2) return 1'b0;
    if (s == 3) return !w && !b;
    return 1'b1;
  endfunction

  // state codes: 0 OFF,1 SS,2 BW,3 RUN,4 FUV,5 FOV (R11 bit positions)
  function automatic int exp_next(int s, bit trip);
    if (!supply_ok) return 0;                       // R3
    case (s)
      0: return en ? 1 : 0;                          // R2
      1: return !en ? 0 : (win ? 2 : 1);             // R4, R8
      2, 3: begin
        if (!en) return 0;
        if (ov) return 5;                            // R9
        if (uv || trip) return 4;                    // R9, R7
        if (s == 2 && xpg) return 3;                 // R5
        return s;
      end
      4: return en ? 4 : 0;                          // R10
      default: return 5;                             // R10
    endcase
  endfunction

  task automatic cyc(bit s, bit e, bit w, bit p, bit b, bit t, bit o, bit u, bit c);
    bit armed, trip;
    int nx;
    @(negedge clk);
    supply_ok = s; en = e; win = w; xpg = p; slew = b; tick = t; ov = o; uv = u; oc = c;
    @(posedge clk);
    armed = (ms == 2 || ms == 3);
    trip  = armed && t && c && (moc == 31);
    nx = exp_next(ms, trip);
    mcap = (ms == 2 && nx == 3);
    if (!armed) moc = 0;
    else if (t) moc = c ? moc + 1 : 0;
    ms = nx;
    #1;
    chk("R11 state", soh, 6'(1 << ms));
    chk("R2 drv_en", {5'd0, drv_en}, {5'd0, (ms >= 1 && ms <= 3)});
    chk("R4 vid_sel", {5'd0, vid_sel}, {5'd0, ms == 3});
    chk("R5 vid_cap", {5'd0, vid_cap}, {5'd0, mcap});
    chk("R6 pg_pull", {5'd0, pg_pull}, {5'd0, exp_pull(ms, w, b)});
  endtask

  task automatic to_run();
    cyc(1,1,0,0,0,0,0,0,0);  // -> SS
    cyc(1,1,1,0,0,0,0,0,0);  // -> BW
    cyc(1,1,1,1,0,0,0,0,0);  // -> RUN, capture
  endtask

  task automatic to_off();
    cyc(0,0,0,0,0,0,0,0,0);
  endtask

  initial begin
    #(200000 * 5);
    miss++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0217);
    #1;
    // R1: reset state
    chk("R1 state", soh, 6'b000001);
    chk("R1 outputs", {2'b0, drv_en, vid_sel, vid_cap, pg_pull}, 6'b000001);
    @(negedge clk); rst_ni = 1'b1;

    // R2: enable without supply keeps drivers off
    cyc(0,1,0,0,0,0,0,0,0);
    chk("R2 no supply", soh, 6'b000001);
    to_run();
    chk("R5 run", soh, 6'b001000);
    // R6: slew mask hides out-of-window in RUN
    cyc(1,1,0,0,1,0,0,0,0);
    chk("R6 masked", {5'd0, pg_pull}, 6'd0);

    // R7: 31 oc ticks, clean tick, 31 oc ticks with idle gaps -> still RUN
    for (int i = 0; i < 31; i++) cyc(1,1,1,0,0,1,0,0,1);
    cyc(1,1,1,0,0,1,0,0,0);
    for (int i = 0; i < 31; i++) begin
      cyc(1,1,1,0,0,1,0,0,1);
      cyc(1,1,1,0,0,0,0,0,0);
    end
    chk("R7 no trip at 31", soh, 6'b001000);
    cyc(1,1,1,0,0,1,0,0,1);
    chk("R7 trip at 32", soh, 6'b010000);
    // R10: UV/OC latch holds with en high, clears on toggle
    cyc(1,1,1,0,0,0,0,0,0);
    chk("R10 uvoc holds", soh, 6'b010000);
    cyc(1,0,0,0,0,0,0,0,0);
    chk("R10 uvoc clears", soh, 6'b000001);

    // R9: ov and uv together pick FAULT_OV
    to_run();
    cyc(1,1,1,0,0,0,1,1,0);
    chk("R9 ov wins", soh, 6'b100000);
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(1,1,0,0,0,0,0,0,0);
    chk("R10 ov ignores en", soh, 6'b100000);
    to_off();
    chk("R3 supply loss", soh, 6'b000001);

    // R8: faults ignored in soft-start
    cyc(1,1,0,0,0,0,0,0,0);
    for (int i = 0; i < 40; i++) cyc(1,1,0,0,0,1,1,1,1);
    chk("R8 ss ignores faults", soh, 6'b000010);
    // R9: uv in BOOT_WAIT
    cyc(1,1,1,0,0,0,0,0,0);
    cyc(1,1,1,0,0,0,0,1,0);
    chk("R9 uv in boot wait", soh, 6'b010000);
    to_off();

    // constrained random, alternating mild and oc-heavy phases
    for (int i = 0; i < 6000; i++) begin
      bit heavy;
      heavy = ((i / 400) % 2) == 1;
      cyc(($urandom % 100) < 98, ($urandom % 100) < (heavy ? 99 : 94),
          ($urandom % 100) < 70, ($urandom % 100) < 30, ($urandom % 100) < 20,
          ($urandom % 100) < 60, (!heavy) && (($urandom % 100) < 1),
          (!heavy) && (($urandom % 100) < 2),
          ($urandom % 100) < (heavy ? 97 : 30));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule